// File: doc/BRIEF.md
# Staggered Two-Slice Pipelined Adder

This block adds or subtracts two 32-bit integers using two narrower adder slices placed one after the other in time. The low slice works on the lower bits of an operand pair and its carry is held in a register. On the next clock the high slice finishes the upper bits of that same pair with the held carry, while the low slice already works on the next pair. Each clock of this block is half of the base cycle, so one complete result needs one full base cycle (two clocks). After that, a new result leaves the block on every clock.

Each operand pair comes with a valid bit and an operation select. Subtraction inverts the second operand and forces a carry of one into the low slice. A pair whose valid bit is low is a bubble: it passes through as an output bubble and changes no output data. The slice boundary and the adder style inside each slice are parameters. The adder style is either the synthesis operator or an explicit bit-level ripple chain.

Top module: `staggered_adder`

## Requirements
- R1: When `op_sub` is 0, a pair accepted with `op_valid` high at a rising edge appears two rising edges later with `res_valid` high, `res_sum` = (A + B) mod 2^DATA_W and `res_carry` = bit DATA_W of the unsigned sum A + B.
- R2: When `op_sub` is 1, the result is `res_sum` = (A - B) mod 2^DATA_W and `res_carry` = 1 exactly when A >= B as unsigned numbers (carry set means no borrow).
- R3: Pairs can be accepted on every clock. The results come out on consecutive clocks in the order the pairs were accepted, and each result depends only on its own pair.
- R4: A clock with `op_valid` low gives `res_valid` low two clocks later. During that output clock `res_sum` and `res_carry` keep the values of the most recent valid result, so the operands that came with the bubble have no effect on the outputs.
- R5: The carry out of the low slice reaches the high slice of the same pair only. This holds when neighbouring pairs alternate between making and not making a carry across the slice boundary.
- R6: With `rst` high at a rising edge, both pipeline stages are cleared: in the next cycle `res_valid`, `res_sum` and `res_carry` are all 0. Results from pairs that were in flight before the reset never appear.
- R7: The result is the same for every legal slice boundary (1 <= SLICE_W < DATA_W) and for both adder styles, the operator (style code 0) and the ripple chain (style code 1).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Half-cycle clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | The operand pair on this clock is to be processed |
| op_sub | input | 1 | 1 selects A - B, 0 selects A + B |
| op_a | input | DATA_W | Operand A |
| op_b | input | DATA_W | Operand B |
| res_valid | output | 1 | A completed result is present |
| res_sum | output | DATA_W | Sum or difference |
| res_carry | output | 1 | Carry out of the top bit (no-borrow flag for subtract) |

## Verification
In every steady-state clock the high slice finishes pair k while the low slice starts pair k+1. Both events share the carry register between the stages. The bench sends back-to-back pairs in which carry-producing and carry-free low halves alternate, and mixes add and subtract. Each output is then compared with the sum computed arithmetically for its own pair, so a carry that lands on the wrong pair shows up as a wrong result. A reset is also asserted while the stages are full, and the bench checks that none of the in-flight results appears afterwards.

// File: rtl/sas_pkg.sv
package sas_pkg;

   // Adder style codes for the slice adders
   localparam int unsigned SAS_ARCH_OPERATOR = 0;
   localparam int unsigned SAS_ARCH_RIPPLE   = 1;

   // Number of half-cycle register stages from acceptance to result
   localparam int unsigned SAS_LATENCY = 2;

   function automatic bit sas_arch_legal(input int unsigned arch);
      return (arch == SAS_ARCH_OPERATOR) || (arch == SAS_ARCH_RIPPLE);
   endfunction

   function automatic bit sas_split_legal(input int unsigned data_w,
                                          input int unsigned slice_w);
      return (slice_w >= 1) && (slice_w < data_w);
   endfunction

endpackage

// File: rtl/sas_operand_prep.sv
module sas_operand_prep #(
   parameter int unsigned W = 32
) (
   input  logic         sub,
   input  logic [W-1:0] b_in,
   output logic [W-1:0] b_eff,
   output logic         cin
);

   // Two's complement subtract: invert B and inject one at the bottom
   assign b_eff = sub ? ~b_in : b_in;
   assign cin   = sub;

endmodule

// File: rtl/sas_slice_adder.sv
module sas_slice_adder
   import sas_pkg::*;
#(
   parameter int unsigned W    = 16,
   parameter int unsigned ARCH = SAS_ARCH_OPERATOR
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         cin,
   output logic [W-1:0] sum,
   output logic         cout
);

   if (ARCH == SAS_ARCH_RIPPLE) begin : g_ripple
      logic [W:0] chain;
      assign chain[0] = cin;
      for (genvar i = 0; i < W; i++) begin : g_bit
         assign sum[i]     = a[i] ^ b[i] ^ chain[i];
         assign chain[i+1] = (a[i] & b[i]) | (chain[i] & (a[i] ^ b[i]));
      end
      assign cout = chain[W];
   end else begin : g_operator
      logic [W:0] total;
      assign total = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
      assign sum   = total[W-1:0];
      assign cout  = total[W];
   end

endmodule

// File: rtl/staggered_adder.sv
module staggered_adder
   import sas_pkg::*;
#(
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned SLICE_W    = 16,
   parameter int unsigned ADDER_ARCH = SAS_ARCH_OPERATOR
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              op_valid,
   input  logic              op_sub,
   input  logic [DATA_W-1:0] op_a,
   input  logic [DATA_W-1:0] op_b,
   output logic              res_valid,
   output logic [DATA_W-1:0] res_sum,
   output logic              res_carry
);

   localparam int unsigned LO_W = SLICE_W;
   localparam int unsigned HI_W = DATA_W - SLICE_W;

   // Elaboration-time parameter checks
   if (!sas_split_legal(DATA_W, SLICE_W)) begin : g_bad_split
      $error("staggered_adder: SLICE_W must be in 1..DATA_W-1");
   end
   if (!sas_arch_legal(ADDER_ARCH)) begin : g_bad_arch
      $error("staggered_adder: unknown ADDER_ARCH");
   end

   // Operand conditioning for add or subtract
   logic [DATA_W-1:0] b_cond;
   logic              cin_lo;

   sas_operand_prep #(.W(DATA_W)) u_prep (
      .sub   (op_sub),
      .b_in  (op_b),
      .b_eff (b_cond),
      .cin   (cin_lo)
   );

   // Low slice: first half-cycle
   logic [LO_W-1:0] lo_sum;
   logic            lo_cout;

   sas_slice_adder #(.W(LO_W), .ARCH(ADDER_ARCH)) u_lo (
      .a    (op_a[LO_W-1:0]),
      .b    (b_cond[LO_W-1:0]),
      .cin  (cin_lo),
      .sum  (lo_sum),
      .cout (lo_cout)
   );

   // Boundary register between the half-cycles
   logic            s1_valid;
   logic [LO_W-1:0] s1_lo_sum;
   logic            s1_carry;
   logic [HI_W-1:0] s1_a_hi;
   logic [HI_W-1:0] s1_b_hi;

   always_ff @(posedge clk) begin
      if (rst) begin
         s1_valid  <= 1'b0;
         s1_lo_sum <= '0;
         s1_carry  <= 1'b0;
         s1_a_hi   <= '0;
         s1_b_hi   <= '0;
      end else begin
         s1_valid <= op_valid;
         if (op_valid) begin
            s1_lo_sum <= lo_sum;
            s1_carry  <= lo_cout;
            s1_a_hi   <= op_a[DATA_W-1:LO_W];
            s1_b_hi   <= b_cond[DATA_W-1:LO_W];
         end
      end
   end

   // High slice: second half-cycle, same pair
   logic [HI_W-1:0] hi_sum;
   logic            hi_cout;

   sas_slice_adder #(.W(HI_W), .ARCH(ADDER_ARCH)) u_hi (
      .a    (s1_a_hi),
      .b    (s1_b_hi),
      .cin  (s1_carry),
      .sum  (hi_sum),
      .cout (hi_cout)
   );

   // Result register, held across bubbles
   always_ff @(posedge clk) begin
      if (rst) begin
         res_valid <= 1'b0;
         res_sum   <= '0;
         res_carry <= 1'b0;
      end else begin
         res_valid <= s1_valid;
         if (s1_valid) begin
            res_sum   <= {hi_sum, s1_lo_sum};
            res_carry <= hi_cout;
         end
      end
   end

endmodule

// File: rtl/sas_checker.sv
module sas_checker #(
   parameter int unsigned DATA_W = 32
) (
   input logic              clk,
   input logic              rst,
   input logic              op_valid,
   input logic              op_sub,
   input logic [DATA_W-1:0] op_a,
   input logic [DATA_W-1:0] op_b,
   input logic              res_valid,
   input logic [DATA_W-1:0] res_sum,
   input logic              res_carry
);

   // Clocks since reset release, saturating at the pipeline depth
   logic [1:0] warm;
   always_ff @(posedge clk) begin
      if (rst)              warm <= 2'd0;
      else if (warm != 2'd2) warm <= warm + 2'd1;
   end

   // Arithmetic reference for the pair on the inputs
   logic [DATA_W:0] ref_full;
   always_comb begin
      if (op_sub) ref_full = {1'b0, op_a} + {1'b0, ~op_b} + {{DATA_W{1'b0}}, 1'b1};
      else        ref_full = {1'b0, op_a} + {1'b0, op_b};
   end

   // R1 R2 R3 R5: every result matches the pair accepted two clocks earlier
   a_r1_result_matches: assert property (@(posedge clk) disable iff (rst)
      (warm == 2'd2 && res_valid) |-> ({res_carry, res_sum} == $past(ref_full, 2)));

   // R3 R4: valid bits travel with their pairs, bubbles stay bubbles
   a_r3_valid_latency: assert property (@(posedge clk) disable iff (rst)
      (warm == 2'd2) |-> (res_valid == $past(op_valid, 2)));

   // R4: outputs hold during a bubble
   a_r4_bubble_hold: assert property (@(posedge clk) disable iff (rst)
      (warm == 2'd2 && !res_valid) |-> ($stable(res_sum) && $stable(res_carry)));

   // R6: reset clears the outputs
   a_r6_reset_clears: assert property (@(posedge clk)
      rst |=> (!res_valid && res_sum == '0 && !res_carry));

   // R6: nothing emerges in the first two clocks after reset
   a_r6_no_stale: assert property (@(posedge clk) disable iff (rst)
      (warm != 2'd2) |-> !res_valid);

endmodule

bind staggered_adder sas_checker #(.DATA_W(DATA_W)) u_sas_checker (
   .clk       (clk),
   .rst       (rst),
   .op_valid  (op_valid),
   .op_sub    (op_sub),
   .op_a      (op_a),
   .op_b      (op_b),
   .res_valid (res_valid),
   .res_sum   (res_sum),
   .res_carry (res_carry)
);

// File: tb/staggered_adder_bench.sv
module staggered_adder_bench;
   import sas_pkg::*;

   localparam int CLK_PERIOD = 10;
   localparam int BW = 32;
   localparam int SW = 6;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #(CLK_PERIOD/2) clk = ~clk;

   // Wide instance, default split, operator style
   logic          b_v = 0, b_sub = 0;
   logic [BW-1:0] b_a = '0, b_b = '0;
   logic          b_rv, b_rc;
   logic [BW-1:0] b_rs;

   staggered_adder u_staggered_adder (
      .clk(clk), .rst(rst), .op_valid(b_v), .op_sub(b_sub), .op_a(b_a), .op_b(b_b),
      .res_valid(b_rv), .res_sum(b_rs), .res_carry(b_rc));

   // Small instance for the exhaustive sweep, ripple style (R7)
   logic          s_v = 0, s_sub = 0;
   logic [SW-1:0] s_a = '0, s_b = '0;
   logic          s_rv, s_rc;
   logic [SW-1:0] s_rs;

   staggered_adder #(.DATA_W(SW), .SLICE_W(3), .ADDER_ARCH(SAS_ARCH_RIPPLE)) u_staggered_adder_small (
      .clk(clk), .rst(rst), .op_valid(s_v), .op_sub(s_sub), .op_a(s_a), .op_b(s_b),
      .res_valid(s_rv), .res_sum(s_rs), .res_carry(s_rc));

   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 0;

   // Expected history, index 1 is the pair driven two steps ago
   logic          bh_v [2];
   logic [BW-1:0] bh_s [2];
   logic          bh_c [2];
   string         bh_t [2];
   logic [BW-1:0] b_last_s;
   logic          b_last_c;

   logic          sh_v [2];
   logic [SW-1:0] sh_s [2];
   logic          sh_c [2];
   string         sh_t [2];
   logic [SW-1:0] s_last_s;
   logic          s_last_c;

   task automatic clear_hist();
      for (int i = 0; i < 2; i++) begin
         bh_v[i] = 0; bh_s[i] = '0; bh_c[i] = 0; bh_t[i] = "R6";
         sh_v[i] = 0; sh_s[i] = '0; sh_c[i] = 0; sh_t[i] = "R6";
      end
      b_last_s = '0; b_last_c = 0;
      s_last_s = '0; s_last_c = 0;
   endtask

   task automatic check_b();
      logic ok;
      logic          ev = bh_v[1];
      logic [BW-1:0] es = ev ? bh_s[1] : b_last_s;
      logic          ec = ev ? bh_c[1] : b_last_c;
      ok = (b_rv === ev) && (b_rs === es) && (b_rc === ec);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: valid=%b sum=%h carry=%b expected valid=%b sum=%h carry=%b",
                  bh_t[1], b_rv, b_rs, b_rc, ev, es, ec);
      end
      if (ev) begin b_last_s = es; b_last_c = ec; end
   endtask

   task automatic check_s();
      logic ok;
      logic          ev = sh_v[1];
      logic [SW-1:0] es = ev ? sh_s[1] : s_last_s;
      logic          ec = ev ? sh_c[1] : s_last_c;
      ok = (s_rv === ev) && (s_rs === es) && (s_rc === ec);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: valid=%b sum=%h carry=%b expected valid=%b sum=%h carry=%b",
                  sh_t[1], s_rv, s_rs, s_rc, ev, es, ec);
      end
      if (ev) begin s_last_s = es; s_last_c = ec; end
   endtask

   // One step of the wide instance; called at a falling edge
   task automatic step_b(input logic v, input logic sub, input logic [BW-1:0] a,
                         input logic [BW-1:0] b, input string tag);
      logic [BW:0] full;
      check_b();
      bh_v[1] = bh_v[0]; bh_s[1] = bh_s[0]; bh_c[1] = bh_c[0]; bh_t[1] = bh_t[0];
      if (sub) begin
         bh_s[0] = a - b;
         bh_c[0] = (a >= b);
      end else begin
         full = {1'b0, a} + {1'b0, b};
         bh_s[0] = full[BW-1:0];
         bh_c[0] = full[BW];
      end
      bh_v[0] = v; bh_t[0] = tag;
      b_v = v; b_sub = sub; b_a = a; b_b = b;
      @(negedge clk);
   endtask

   task automatic step_s(input logic v, input logic sub, input logic [SW-1:0] a,
                         input logic [SW-1:0] b, input string tag);
      logic [SW:0] full;
      check_s();
      sh_v[1] = sh_v[0]; sh_s[1] = sh_s[0]; sh_c[1] = sh_c[0]; sh_t[1] = sh_t[0];
      if (sub) begin
         sh_s[0] = a - b;
         sh_c[0] = (a >= b);
      end else begin
         full = {1'b0, a} + {1'b0, b};
         sh_s[0] = full[SW-1:0];
         sh_c[0] = full[SW];
      end
      sh_v[0] = v; sh_t[0] = tag;
      s_v = v; s_sub = sub; s_a = a; s_b = b;
      @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog: run did not end, expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin : main
      logic [31:0] lfsr;
      clear_hist();
      repeat (3) @(negedge clk);
      // R6: reset state on both instances
      check_b();
      check_s();
      rst = 0;

      // R1: plain additions
      step_b(1, 0, 32'h0000_0000, 32'h0000_0000, "R1");
      step_b(1, 0, 32'h1234_5678, 32'h9ABC_DEF0, "R1");
      step_b(1, 0, 32'hFFFF_FFFF, 32'h0000_0001, "R1");
      step_b(1, 0, 32'h8000_0000, 32'h8000_0000, "R1");
      step_b(1, 0, 32'h7FFF_FFFF, 32'h0000_0001, "R1");

      // R2: subtractions, including borrow across the slice boundary
      step_b(1, 1, 32'h0000_0005, 32'h0000_0007, "R2");
      step_b(1, 1, 32'h0000_0007, 32'h0000_0005, "R2");
      step_b(1, 1, 32'hCAFE_F00D, 32'hCAFE_F00D, "R2");
      step_b(1, 1, 32'h0000_0000, 32'h0000_0001, "R2");
      step_b(1, 1, 32'h0001_0000, 32'h0000_0001, "R2");
      step_b(1, 1, 32'h8000_0000, 32'hFFFF_FFFF, "R2");

      // R5: alternate carry / no carry across the boundary, back to back
      for (int i = 0; i < 32; i++) begin
         logic [31:0] a = 32'h0000_FFFF + (i << 16);
         logic [31:0] b = (i % 2 == 1) ? 32'h0000_0001 : 32'h0000_0000;
         step_b(1, (i % 4 == 3), a, b, "R5");
      end

      // R3: sustained back-to-back mixed traffic
      lfsr = 32'hACE1_2468;
      for (int i = 0; i < 64; i++) begin
         logic [31:0] a, b;
         lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
         a = lfsr;
         lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
         b = lfsr;
         step_b(1, lfsr[3], a, b, "R3");
      end

      // R4: bubbles carrying garbage operands
      step_b(1, 0, 32'h0000_1111, 32'h0000_2222, "R4");
      step_b(0, 0, 32'hDEAD_BEEF, 32'hFFFF_FFFF, "R4");
      step_b(0, 1, 32'h0BAD_F00D, 32'h1234_5678, "R4");
      step_b(1, 1, 32'h0000_0010, 32'h0000_0020, "R4");
      step_b(0, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R4");
      step_b(1, 0, 32'hFFFF_0000, 32'h0001_0000, "R4");
      step_b(0, 1, 32'h5555_AAAA, 32'hAAAA_5555, "R4");
      step_b(0, 0, 32'h0000_0000, 32'h0000_0000, "R4");

      // R6: reset with both stages full
      step_b(1, 0, 32'h1111_1111, 32'h2222_2222, "R6");
      b_v = 1; b_a = 32'h3333_3333; b_b = 32'h4444_4444; b_sub = 0;
      rst = 1;
      @(negedge clk);
      clear_hist();
      check_b();
      b_v = 0;
      @(negedge clk);
      rst = 0;
      step_b(0, 0, 32'h9999_9999, 32'h9999_9999, "R6");
      step_b(0, 0, 32'h9999_9999, 32'h9999_9999, "R6");
      step_b(0, 0, '0, '0, "R6");
      step_b(1, 0, 32'h0000_0001, 32'h0000_0002, "R1");
      step_b(0, 0, '0, '0, "R4");
      step_b(0, 0, '0, '0, "R4");
      step_b(0, 0, '0, '0, "R4");

      // R7: exhaustive sweep of the small ripple-style instance
      for (int sub = 0; sub < 2; sub++) begin
         for (int a = 0; a < 64; a++) begin
            for (int b = 0; b < 64; b++) begin
               step_s(1, sub[0], a[SW-1:0], b[SW-1:0], sub ? "R2/R7" : "R1/R7");
               if ((a * 64 + b) % 29 == 0)
                  step_s(0, 1, 6'h3F, 6'h15, "R4/R7");
            end
         end
      end
      step_s(0, 0, '0, '0, "R4");
      step_s(0, 0, '0, '0, "R4");
      step_s(0, 0, '0, '0, "R4");

      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule